// File: doc/BRIEF.md
# Comma-Aligning Character Deserializer

This block takes a retimed serial stream, one bit per cycle in which the bit enable is high. It packs the bits into 10-bit characters, with the earliest bit in bit 0. Characters leave the block in alternation, tagged even and odd, as the two halves of a 20-bit half-word. Once the odd half arrives, the pair is also presented as a single 20-bit word.

While alignment is switched on, every new bit is checked against a 7-bit comma pattern over a sliding window. If that pattern is found anywhere other than the start of an even character, the character grid and the half-word phase both move so that the comma comes out as a complete even character. The characters after it follow on the new grid. A flag marks the comma character for as long as that character is on the output. While alignment is switched off, the grid and phase stay where they are, whatever data arrives.

Top module: `comma_align_deser`

## Requirements
- R1: After synchronous reset, `char_out`, `half_word`, `char_stb`, `half_stb`, `char_odd` and `comma_flag` are all zero. The bit grid restarts at offset 0, and the first character is even.
- R2: Bit i of `char_out` is the i-th bit received in that character, so bit 0 is the earliest. With the alignment unchanged, a character is presented, with a one-cycle `char_stb`, after every 10th bit accepted. Cycles with `bit_en` low neither shift a bit in nor advance the grid.
- R3: Without realignment, successive characters alternate between even (`char_odd`=0) and odd (`char_odd`=1), starting with even.
- R4: When an odd character is presented, one cycle later `half_stb` pulses and `half_word` holds the odd character in bits 19..10 and the preceding even character in bits 9..0.
- R5: The comma is bits 0..6 of a character equal to 0,0,1,1,1,1,1 (bit 0 first), which is `char_out[6:0]` = 7'b1111100. Bits 7..9 are ignored, and the pattern is looked for at every bit position.
- R6: With `align_en` high, a comma found at a nonzero offset inside the current grid is presented as a whole character once its 10th bit arrives. The next character follows exactly 10 bits later.
- R7: With `align_en` high, a comma that falls on the odd phase, including a second comma directly after another, is presented as an even character. The character after it is odd.
- R8: A comma that is already at bits 0..6 of an even character changes neither the grid nor the phase, and it still raises `comma_flag`.
- R9: `comma_flag` is raised only for a comma seen while `align_en` is high. It is set together with that comma character and cleared when the next character is presented.
- R10: With `align_en` low, commas at any offset cause no realignment and no flag. Characters keep coming every 10 bits on the grid already in place.
- R11: With `align_en` high, a comma that straddles two grid characters is presented whole as an even character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Serial data bit |
| align_en | input | 1 | Enables comma search and realignment |
| char_out | output | 10 | Current character, bit 0 earliest |
| char_stb | output | 1 | One-cycle pulse when `char_out` is updated |
| char_odd | output | 1 | Phase of `char_out`: 0 even, 1 odd |
| comma_flag | output | 1 | `char_out` is a comma seen with alignment enabled |
| half_word | output | 20 | Odd character over preceding even character |
| half_stb | output | 1 | One-cycle pulse when `half_word` is updated |

## Verification
The main function is driven with plain data at the reset grid, which separates correct bit ordering and phase alternation from a swapped or shifted packing. Commas are placed at a small in-grid offset, at a straddling offset, on the odd phase, twice in a row, and already aligned. Each case shows whether the grid and the phase move by exactly the right amount, or not at all. A run with alignment disabled and a comma off the grid checks that no flag appears and the old grid holds. Enabling alignment afterwards shows that the block recovers. Every bit is followed by an idle cycle carrying the inverted bit, which shows whether ignored cycles leak into the data.

// File: rtl/cad_pkg.sv
`timescale 1ns/1ps
package cad_pkg;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;
endpackage

// File: rtl/cad_bit_window.sv
`timescale 1ns/1ps
// Shift window: newest bit enters at the top, oldest sits at bit 0.
module cad_bit_window #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] win_nxt
);
  logic [W-1:0] win_q;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W-1) begin : g_top
      assign win_nxt[i] = din;
    end else begin : g_mid
      assign win_nxt[i] = win_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else if (shift_en) win_q <= win_nxt;
  end
endmodule

// File: rtl/cad_comma_match.sv
`timescale 1ns/1ps
// Bitwise pattern compare on the oldest bits of the window.
module cad_comma_match #(
  parameter int PW = 7,
  parameter logic [PW-1:0] PAT = 7'b1111100
) (
  input  logic          enable,
  input  logic [PW-1:0] win_lo,
  output logic          hit
);
  logic [PW-1:0] eq;

  for (genvar i = 0; i < PW; i++) begin : g_eq
    assign eq[i] = (win_lo[i] == PAT[i]);
  end

  assign hit = enable & (&eq);
endmodule

// File: rtl/cad_char_framer.sv
`timescale 1ns/1ps
// Bit counter, phase tracking and registered character outputs.
module cad_char_framer
  import cad_pkg::*;
#(
  parameter int W  = 10,
  parameter int PW = 7,
  parameter logic [PW-1:0] PAT = 7'b1111100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_en,
  input  logic         align_en,
  input  logic [W-1:0] win_nxt,
  input  logic         hit,
  output logic [W-1:0] char_q,
  output logic         char_stb,
  output logic         char_odd,
  output logic         comma_q
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic [CW-1:0] cnt;
  phase_e        next_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      next_ph  <= PH_EVEN;
      char_q   <= '0;
      char_stb <= 1'b0;
      char_odd <= 1'b0;
      comma_q  <= 1'b0;
    end else begin
      char_stb <= 1'b0;
      if (bit_en) begin
        if (hit) begin
          char_q   <= win_nxt;
          char_stb <= 1'b1;
          char_odd <= 1'b0;
          comma_q  <= 1'b1;
          cnt      <= '0;
          next_ph  <= PH_ODD;
        end else if (cnt == LAST) begin
          char_q   <= win_nxt;
          char_stb <= 1'b1;
          char_odd <= (next_ph == PH_ODD);
          comma_q  <= 1'b0;
          cnt      <= '0;
          next_ph  <= (next_ph == PH_EVEN) ? PH_ODD : PH_EVEN;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r2_stb_after_bit: assert property (@(posedge clk) disable iff (rst)
    char_stb |-> $past(bit_en));
  a_r9_flag_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (char_stb && comma_q) |-> $past(align_en));
  a_r7_comma_even: assert property (@(posedge clk) disable iff (rst)
    comma_q |-> !char_odd);
  a_r5_comma_shape: assert property (@(posedge clk) disable iff (rst)
    comma_q |-> (char_q[PW-1:0] == PAT));
endmodule

// File: rtl/cad_half_pack.sv
`timescale 1ns/1ps
// Pairs an even character with the following odd one.
module cad_half_pack #(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           char_stb,
  input  logic           char_odd,
  input  logic [W-1:0]   char_in,
  output logic [2*W-1:0] half_q,
  output logic           half_stb
);
  logic [W-1:0] even_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      even_hold <= '0;
      half_q    <= '0;
      half_stb  <= 1'b0;
    end else begin
      half_stb <= 1'b0;
      if (char_stb && !char_odd) even_hold <= char_in;
      if (char_stb && char_odd) begin
        half_q   <= {char_in, even_hold};
        half_stb <= 1'b1;
      end
    end
  end

  a_r4_half_follows_odd: assert property (@(posedge clk) disable iff (rst)
    half_stb |-> $past(char_stb && char_odd));
  a_r4_half_upper: assert property (@(posedge clk) disable iff (rst)
    half_stb |-> (half_q[2*W-1:W] == $past(char_in)));
endmodule

// File: rtl/comma_align_deser.sv
`timescale 1ns/1ps
module comma_align_deser #(
  parameter int CHAR_W = 10,
  parameter int PAT_W  = 7,
  parameter logic [PAT_W-1:0] COMMA = 7'b1111100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic                rx_bit,
  input  logic                align_en,
  output logic [CHAR_W-1:0]   char_out,
  output logic                char_stb,
  output logic                char_odd,
  output logic                comma_flag,
  output logic [2*CHAR_W-1:0] half_word,
  output logic                half_stb
);
  logic [CHAR_W-1:0] win_nxt;
  logic              hit;

  cad_bit_window #(.W(CHAR_W)) u_win (
    .clk(clk), .rst(rst), .shift_en(bit_en), .din(rx_bit), .win_nxt(win_nxt)
  );

  cad_comma_match #(.PW(PAT_W), .PAT(COMMA)) u_match (
    .enable(align_en), .win_lo(win_nxt[PAT_W-1:0]), .hit(hit)
  );

  cad_char_framer #(.W(CHAR_W), .PW(PAT_W), .PAT(COMMA)) u_frame (
    .clk(clk), .rst(rst), .bit_en(bit_en), .align_en(align_en),
    .win_nxt(win_nxt), .hit(hit), .char_q(char_out), .char_stb(char_stb),
    .char_odd(char_odd), .comma_q(comma_flag)
  );

  cad_half_pack #(.W(CHAR_W)) u_half (
    .clk(clk), .rst(rst), .char_stb(char_stb), .char_odd(char_odd),
    .char_in(char_out), .half_q(half_word), .half_stb(half_stb)
  );

  a_r10_no_flag_disabled: assert property (@(posedge clk) disable iff (rst)
    (char_stb && !$past(align_en)) |-> !comma_flag);
endmodule

// File: tb/sim_comma_align_deser.sv
`timescale 1ns/1ps
module sim_comma_align_deser;
  logic clk = 1'b0;
  logic rst, bit_en, rx_bit, align_en;
  logic [9:0]  char_out;
  logic        char_stb, char_odd, comma_flag, half_stb;
  logic [19:0] half_word;

  always #4 clk = ~clk;

  comma_align_deser u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .align_en(align_en),
    .char_out(char_out), .char_stb(char_stb), .char_odd(char_odd),
    .comma_flag(comma_flag), .half_word(half_word), .half_stb(half_stb)
  );

  localparam logic [9:0] K = 10'h17C;
  int total = 0;
  int bad = 0;
  logic stream [0:511];
  int nbits;
  int stb_n;
  logic stb_seen;

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic aen);
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b0; align_en = aen;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nbits = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; rx_bit = ~b;
    stb_seen = char_stb;
    stream[nbits] = b;
    nbits++;
  endtask

  task automatic send_char(input logic [9:0] c);
    stb_n = 0;
    for (int i = 0; i < 10; i++) begin
      send_bit(c[i]);
      if (stb_seen) stb_n++;
    end
  endtask

  task automatic idle1();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk(char_out == 0 && half_word == 0, "R1 data", {12'b0, half_word}, 0);
    chk(!char_stb && !half_stb && !char_odd && !comma_flag, "R1 flags",
        {char_stb, half_stb, char_odd, comma_flag}, 0);
  endtask

  task automatic t_plain();
    do_reset(1'b0);
    send_char(10'h0F3);
    chk(stb_n == 1 && stb_seen, "R2 one strobe on 10th bit", stb_n, 1);
    chk(char_out == 10'h0F3, "R2 bit order", char_out, 10'h0F3);
    chk(char_odd == 1'b0, "R3 first even", char_odd, 0);
    send_char(10'h2C6);
    chk(char_out == 10'h2C6, "R2 second char", char_out, 10'h2C6);
    chk(char_odd == 1'b1, "R3 second odd", char_odd, 1);
    idle1();
    chk(half_stb == 1'b1, "R4 half strobe", half_stb, 1);
    chk(half_word == {10'h2C6, 10'h0F3}, "R4 half word", half_word, {10'h2C6, 10'h0F3});
    send_char(10'h01D);
    chk(char_odd == 1'b0 && char_out == 10'h01D, "R3 third even", {char_odd, char_out}, 10'h01D);
  endtask

  task automatic t_offset(input int nfill, input string req);
    do_reset(1'b1);
    for (int i = 0; i < nfill; i++) send_bit(i % 2 == 0);
    send_char(K);
    chk(stb_seen && char_out == K, {req, " comma whole"}, char_out, K);
    chk(comma_flag && !char_odd, {req, " flag even"}, {comma_flag, char_odd}, 2'b10);
    chk(char_out[6:0] == 7'b1111100, "R5 comma bits", char_out[6:0], 7'b1111100);
    send_char(10'h155);
    chk(stb_n == 1 && stb_seen && char_out == 10'h155, {req, " next on grid"},
        {stb_n[3:0], char_out}, {4'd1, 10'h155});
    chk(char_odd && !comma_flag, "R9 flag one char", {char_odd, comma_flag}, 2'b10);
  endtask

  task automatic t_phase();
    do_reset(1'b1);
    send_char(10'h155);
    chk(!char_odd, "R7 lead even", char_odd, 0);
    send_char(K);
    chk(stb_n == 1 && comma_flag && !char_odd && char_out == K, "R7 moved to even",
        {comma_flag, char_odd, char_out}, {2'b10, K});
    send_char(10'h2AA);
    chk(char_odd && char_out == 10'h2AA, "R7 follower odd", {char_odd, char_out}, {1'b1, 10'h2AA});
  endtask

  task automatic t_aligned();
    do_reset(1'b1);
    send_char(K);
    chk(stb_n == 1 && comma_flag && !char_odd, "R8 first comma", {stb_n[3:0], comma_flag, char_odd}, {4'd1, 2'b10});
    send_char(10'h155);
    chk(stb_n == 1 && char_odd && !comma_flag, "R8 data odd", {stb_n[3:0], char_odd, comma_flag}, {4'd1, 2'b10});
    idle1();
    chk(half_word == {10'h155, K}, "R4 comma half", half_word, {10'h155, K});
    send_char(K);
    chk(stb_n == 1 && comma_flag && !char_odd && char_out == K, "R8 aligned again",
        {stb_n[3:0], comma_flag, char_odd}, {4'd1, 2'b10});
  endtask

  task automatic t_double();
    do_reset(1'b1);
    send_char(K);
    send_char(K);
    chk(comma_flag && !char_odd && char_out == K, "R7 second comma even", {comma_flag, char_odd}, 2'b10);
    send_char(10'h2AA);
    chk(char_odd && !comma_flag, "R7 after pair", {char_odd, comma_flag}, 2'b10);
  endtask

  task automatic t_frozen();
    logic [9:0] exp;
    int nst;
    logic [9:0] seq [0:2];
    do_reset(1'b0);
    seq[0] = K; seq[1] = 10'h155; seq[2] = 10'h2AA;
    nst = 0;
    for (int i = 0; i < 3; i++) send_bit(i != 1);
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < 10; i++) begin
        send_bit(seq[c][i]);
        if (stb_seen) begin
          nst++;
          for (int j = 0; j < 10; j++) exp[j] = stream[nbits - 10 + j];
          chk(char_out == exp && !comma_flag, "R10 grid kept no flag",
              {comma_flag, char_out}, {1'b0, exp});
        end
      end
    end
    chk(nst == 3 && nbits % 10 == 3, "R10 strobe count", nst, 3);
    align_en = 1'b1;
    send_char(K);
    chk(comma_flag && !char_odd && char_out == K, "R6 realign after enable",
        {comma_flag, char_odd, char_out}, {2'b10, K});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b0; align_en = 1'b0;
    t_reset();
    t_plain();
    t_offset(2, "R6");
    t_offset(7, "R11");
    t_phase();
    t_aligned();
    t_double();
    t_frozen();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule